// File: doc/BRIEF.md
# Page-Pointer Scatter List Walker

This block expands a host transfer descriptor into an ordered stream of memory segments, each an (address, byte length) pair, for a downstream data mover. A descriptor carries a first data pointer, a second pointer and a total byte length. The memory page size is selected per walk by a small size code. The first segment runs from the first pointer to the end of its page, or to the end of the transfer if that comes sooner. If the rest of the transfer fits in one page, the second pointer addresses it directly. Otherwise the second pointer addresses a list of 64-bit page pointers.

The walker requests list entries through a fetch port: an address and an entry count go out on one handshake, and the entries come back in order on a separate valid/ready stream. A full list page that cannot cover the rest of the transfer gives its final slot to a link pointing at the next list page, so lists of any length can be walked. Every pointer is checked for zero and for page alignment. A bad pointer ends the walk with an invalid-field status that has the do-not-retry bit set. No segment follows the error. Entries still owed by the fetch port are drained before the walker goes idle.

Top module: `prp_walker`

## Requirements
- R1: The page size is 2^(mps_i+12) bytes. The first segment starts at ptr1_i, and its length is the smaller of len_i and the page size minus (ptr1_i mod page size).
- R2: A start with ptr1_i equal to zero emits no segment and reports an error.
- R3: When the first segment covers the whole transfer, done follows with no fetch. When no more than one page remains after it, a single segment of the remaining length is emitted at ptr2_i, with no fetch.
- R4: In the direct case of R3, a ptr2_i that is zero or has any bit below the page size set gives an error, and no segment is emitted, not even the first one.
- R5: When more than one page remains, one fetch request is issued at address ptr2_i. Its entry count is the smaller of page size/8 and the remaining pages rounded up. Each returned entry yields one segment at that entry, with length min(remaining, page size).
- R6: An entry in the final slot of a list page (slot page size/8 − 1) while more than one page of data remains is a link. A new fetch is issued at its address, and no segment is emitted for it.
- R7: A data entry that is zero or not page aligned gives an error and no further segment. The rest of the fetched batch is accepted and discarded, and the walker then returns to idle and accepts a new start.
- R8: A link entry (R6) that is zero or not page aligned gives an error, and no further fetch follows.
- R9: While seg_valid_o is high and seg_ready_i is low, the segment address and length hold steady.
- R10: A walk ends with a one-cycle pulse on done_o or on err_o, never both. done_o pulses only after the last segment has been accepted. While err_o is high, err_status_o has bit 15 (do-not-retry) set, bits 7:0 equal 0x02 (invalid field) and all other bits clear. Outside the pulse it is zero.
- R11: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk with the descriptor inputs (idle only) |
| mps_i | input | MPS_W | Page size code, page = 2^(mps_i+12) |
| ptr1_i | input | ADDR_W | First data pointer |
| ptr2_i | input | ADDR_W | Second pointer: direct data or list address |
| len_i | input | LEN_W | Total transfer length in bytes |
| busy_o | output | 1 | Walk in progress |
| seg_valid_o | output | 1 | Segment available |
| seg_ready_i | input | 1 | Consumer accepts the segment |
| seg_addr_o | output | ADDR_W | Segment start address |
| seg_len_o | output | LEN_W | Segment byte length |
| fetch_valid_o | output | 1 | List fetch request |
| fetch_ready_i | input | 1 | Fetch request accepted |
| fetch_addr_o | output | ADDR_W | Address of the first entry to fetch |
| fetch_cnt_o | output | EPP_W | Number of 64-bit entries requested |
| ent_valid_i | input | 1 | Returned list entry valid |
| ent_ready_o | output | 1 | Walker accepts the entry |
| ent_data_i | input | 64 | Returned list entry, already in host order |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse on a pointer error |
| err_status_o | output | 16 | Error status during err_o, else zero |

## Verification
The assertions assume that mps_i at a start never exceeds MPS_MAX and that len_i is at least one byte. They also assume that the fetch responder returns exactly the requested number of entries, in order, only after it has accepted a request. The bench keeps to these assumptions: it uses size codes 0 and 1 and nonzero lengths. Its responder model serves each accepted request from a sparse memory, one entry per handshake, and stops at the requested count. The ready lines follow fixed duty patterns, so stalls land on both the segment and the fetch side.

// File: rtl/prp_pkg.sv
package prp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_DIRECT,
    ST_REQ,
    ST_ENT,
    ST_FIN,
    ST_DRAIN
  } walk_st_e;

  localparam logic [7:0] SC_BAD_FIELD = 8'h02;
  localparam int         NO_RETRY_BIT = 15;
  localparam int         PAGE_SHIFT_MIN = 12;
endpackage

// File: rtl/prp_geom.sv
module prp_geom import prp_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int MPS_W  = 4,
  parameter int EPP_W  = 14
) (
  input  logic [MPS_W-1:0]  mps_i,
  input  logic [LEN_W-1:0]  ptr_lo_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [LEN_W-1:0]  page_len_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic [LEN_W-1:0]  first_len_o,
  output logic [EPP_W-1:0]  batch_o,
  output logic [EPP_W-1:0]  last_slot_o
);
  localparam int WW = LEN_W + 1;

  int unsigned     pb;
  logic [WW-1:0]   page_w, mask_w, room_w, pages_w, rem_w;
  logic [EPP_W-1:0] epp;

  always_comb begin
    pb       = PAGE_SHIFT_MIN + 32'(mps_i);
    page_w   = WW'(1) << pb;
    mask_w   = page_w - WW'(1);
    rem_w    = {1'b0, rem_i};
    room_w   = page_w - ({1'b0, ptr_lo_i} & mask_w);
    pages_w  = (rem_w + mask_w) >> pb;
    epp      = EPP_W'(1) << (pb - 3);
    first_len_o = (rem_w < room_w) ? rem_i : room_w[LEN_W-1:0];
    batch_o     = (pages_w < WW'(epp)) ? pages_w[EPP_W-1:0] : epp;
    last_slot_o = epp - EPP_W'(1);
    page_len_o  = page_w[LEN_W-1:0];
    mask_o      = {{(ADDR_W-WW){1'b0}}, mask_w};
  end
endmodule

// File: rtl/prp_seg_reg.sv
module prp_seg_reg #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ready_i,
  output logic              can_load_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  assign can_load_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      len_o   <= '0;
    end else if (load_i && can_load_o) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      len_o   <= len_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prp_batch_ctr.sv
module prp_batch_ctr #(
  parameter int EPP_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [EPP_W-1:0] cnt_i,
  input  logic             step_i,
  output logic [EPP_W-1:0] slot_o,
  output logic [EPP_W-1:0] left_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o <= '0;
      left_o <= '0;
    end else if (load_i) begin
      slot_o <= '0;
      left_o <= cnt_i;
    end else if (step_i) begin
      slot_o <= slot_o + EPP_W'(1);
      left_o <= left_o - EPP_W'(1);
    end
  end
endmodule

// File: rtl/prp_walker.sv
module prp_walker import prp_pkg::*; #(
  parameter  int ADDR_W  = 64,
  parameter  int LEN_W   = 32,
  parameter  int MPS_W   = 4,
  parameter  int MPS_MAX = 4,
  localparam int EPP_W   = 10 + MPS_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MPS_W-1:0]  mps_i,
  input  logic [ADDR_W-1:0] ptr1_i,
  input  logic [ADDR_W-1:0] ptr2_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic [LEN_W-1:0]  seg_len_o,
  output logic              fetch_valid_o,
  input  logic              fetch_ready_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [EPP_W-1:0]  fetch_cnt_o,
  input  logic              ent_valid_i,
  output logic              ent_ready_o,
  input  logic [63:0]       ent_data_i,
  output logic              done_o,
  output logic              err_o,
  output logic [15:0]       err_status_o
);
  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] p1_q, p1_d, p2_q, p2_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [MPS_W-1:0]  mps_q, mps_d;
  logic              done_q, done_d, err_q, err_d;

  logic [LEN_W-1:0]  page_len, first_len, rem_after, data_len;
  logic [ADDR_W-1:0] mask;
  logic [EPP_W-1:0]  batch, last_slot, slot, left;

  logic              seg_load, seg_can;
  logic [ADDR_W-1:0] seg_addr_d;
  logic [LEN_W-1:0]  seg_len_d;
  logic              ctr_load, ctr_step;
  logic [ADDR_W-1:0] ent_addr;
  logic              ent_fire, ent_bad, is_link, p2_misaligned;

  prp_geom #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .EPP_W(EPP_W)) u_geom (
    .mps_i      (mps_q),
    .ptr_lo_i   (p1_q[LEN_W-1:0]),
    .rem_i      (rem_q),
    .page_len_o (page_len),
    .mask_o     (mask),
    .first_len_o(first_len),
    .batch_o    (batch),
    .last_slot_o(last_slot)
  );

  prp_seg_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (seg_load),
    .addr_i    (seg_addr_d),
    .len_i     (seg_len_d),
    .ready_i   (seg_ready_i),
    .can_load_o(seg_can),
    .valid_o   (seg_valid_o),
    .addr_o    (seg_addr_o),
    .len_o     (seg_len_o)
  );

  prp_batch_ctr #(.EPP_W(EPP_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ctr_load),
    .cnt_i (batch),
    .step_i(ctr_step),
    .slot_o(slot),
    .left_o(left)
  );

  assign ent_addr      = ADDR_W'(ent_data_i);
  assign ent_ready_o   = ((st_q == ST_ENT) && seg_can) || (st_q == ST_DRAIN);
  assign ent_fire      = ent_valid_i && ent_ready_o;
  assign ent_bad       = (ent_addr == '0) || ((ent_addr & mask) != '0);
  assign is_link       = (slot == last_slot) && (rem_q > page_len);
  assign p2_misaligned = (p2_q & mask) != '0;
  assign rem_after     = rem_q - first_len;
  assign data_len      = (rem_q < page_len) ? rem_q : page_len;

  assign busy_o        = (st_q != ST_IDLE);
  assign fetch_valid_o = (st_q == ST_REQ);
  assign fetch_addr_o  = p2_q;
  assign fetch_cnt_o   = batch;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_status_o  = err_q ? (16'(SC_BAD_FIELD) | (16'd1 << NO_RETRY_BIT)) : 16'd0;

  always_comb begin
    st_d       = st_q;
    p1_d       = p1_q;
    p2_d       = p2_q;
    rem_d      = rem_q;
    mps_d      = mps_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    seg_load   = 1'b0;
    seg_addr_d = '0;
    seg_len_d  = '0;
    ctr_load   = 1'b0;
    ctr_step   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          p1_d  = ptr1_i;
          p2_d  = ptr2_i;
          rem_d = len_i;
          mps_d = mps_i;
          if (ptr1_i == '0) err_d = 1'b1;
          else              st_d  = ST_FIRST;
        end
      end
      ST_FIRST: begin
        // second pointer is checked before anything leaves the block
        if (rem_after != '0 &&
            (p2_q == '0 || (rem_after <= page_len && p2_misaligned))) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else if (seg_can) begin
          seg_load   = 1'b1;
          seg_addr_d = p1_q;
          seg_len_d  = first_len;
          rem_d      = rem_after;
          if (rem_after == '0)            st_d = ST_FIN;
          else if (rem_after <= page_len) st_d = ST_DIRECT;
          else                            st_d = ST_REQ;
        end
      end
      ST_DIRECT: begin
        if (seg_can) begin
          seg_load   = 1'b1;
          seg_addr_d = p2_q;
          seg_len_d  = rem_q;
          rem_d      = '0;
          st_d       = ST_FIN;
        end
      end
      ST_REQ: begin
        if (fetch_ready_i) begin
          ctr_load = 1'b1;
          st_d     = ST_ENT;
        end
      end
      ST_ENT: begin
        if (ent_fire) begin
          ctr_step = 1'b1;
          if (ent_bad) begin
            err_d = 1'b1;
            st_d  = (left == EPP_W'(1)) ? ST_IDLE : ST_DRAIN;
          end else if (is_link) begin
            p2_d = ent_addr;
            st_d = ST_REQ;
          end else begin
            seg_load   = 1'b1;
            seg_addr_d = ent_addr;
            seg_len_d  = data_len;
            rem_d      = rem_q - data_len;
            if (rem_q == data_len) st_d = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        if (!seg_valid_o) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (ent_valid_i) begin
          ctr_step = 1'b1;
          if (left == EPP_W'(1)) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      p1_q   <= '0;
      p2_q   <= '0;
      rem_q  <= '0;
      mps_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      p1_q   <= p1_d;
      p2_q   <= p2_d;
      rem_q  <= rem_d;
      mps_q  <= mps_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/prp_walker_chk.sv
module prp_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int MPS_W  = 4,
  parameter int EPP_W  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic [MPS_W-1:0]  mps_i,
  input logic              seg_valid_o,
  input logic              seg_ready_i,
  input logic [ADDR_W-1:0] seg_addr_o,
  input logic [LEN_W-1:0]  seg_len_o,
  input logic              fetch_valid_o,
  input logic              fetch_ready_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [EPP_W-1:0]  fetch_cnt_o,
  input logic              ent_ready_o,
  input logic              done_o,
  input logic              err_o
);
  logic [MPS_W-1:0] mps_lat;
  logic [LEN_W:0]   page_lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mps_lat <= '0;
    else if (start_i && !busy_o) mps_lat <= mps_i;
  end
  assign page_lat = (LEN_W+1)'(1) << (12 + 32'(mps_lat));

  assert_seg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o));

  assert_seg_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> (seg_len_o != '0) && ({1'b0, seg_len_o} <= page_lat));

  assert_fetch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && !fetch_ready_i |=> fetch_valid_o && $stable(fetch_addr_o) && $stable(fetch_cnt_o));

  assert_fetch_sane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> (fetch_addr_o != '0) && (fetch_cnt_o != '0));

  assert_done_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !seg_valid_o && !err_o && !busy_o);

  assert_err_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !seg_valid_o && !fetch_valid_o);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !seg_valid_o && !fetch_valid_o && !ent_ready_o);
endmodule

bind prp_walker prp_walker_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .EPP_W(EPP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .mps_i(mps_i),
  .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i), .seg_addr_o(seg_addr_o),
  .seg_len_o(seg_len_o), .fetch_valid_o(fetch_valid_o), .fetch_ready_i(fetch_ready_i),
  .fetch_addr_o(fetch_addr_o), .fetch_cnt_o(fetch_cnt_o), .ent_ready_o(ent_ready_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_prp_walker.sv
`timescale 1ns/1ps
module tb_prp_walker;
  typedef struct packed { logic [63:0] a; logic [31:0] l; } seg_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mps = '0;
  logic [63:0] p1 = '0, p2 = '0;
  logic [31:0] len = '0;
  logic        busy, seg_valid, seg_ready, fetch_valid, fetch_ready;
  logic [63:0] seg_addr, fetch_addr, ent_data;
  logic [31:0] seg_len;
  logic [13:0] fetch_cnt;
  logic        ent_valid, ent_ready, done, err;
  logic [15:0] err_status;

  int n_chk = 0, n_fail = 0;
  bit hold = 1'b0;
  int cyc = 0;
  seg_t seg_q[$], exp_q[$];
  logic [63:0] fa_q[$];
  int fc_q[$];
  logic [63:0] mem [logic [63:0]];
  logic [63:0] r_addr;
  int r_cnt, r_idx;

  always #10 clk = ~clk;

  prp_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mps_i(mps), .ptr1_i(p1), .ptr2_i(p2),
    .len_i(len), .busy_o(busy), .seg_valid_o(seg_valid), .seg_ready_i(seg_ready),
    .seg_addr_o(seg_addr), .seg_len_o(seg_len), .fetch_valid_o(fetch_valid),
    .fetch_ready_i(fetch_ready), .fetch_addr_o(fetch_addr), .fetch_cnt_o(fetch_cnt),
    .ent_valid_i(ent_valid), .ent_ready_o(ent_ready), .ent_data_i(ent_data),
    .done_o(done), .err_o(err), .err_status_o(err_status)
  );

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  // consumer and list responder models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_ready <= 1'b0; fetch_ready <= 1'b0; ent_valid <= 1'b0; ent_data <= '0;
      r_addr <= '0; r_cnt <= 0; r_idx <= 0; cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (seg_valid && seg_ready) seg_q.push_back('{a: seg_addr, l: seg_len});
      seg_ready   <= !hold && (cyc % 3 != 0);
      fetch_ready <= (cyc % 2 == 0);
      if (fetch_valid && fetch_ready) begin
        fa_q.push_back(fetch_addr); fc_q.push_back(int'(fetch_cnt));
        r_addr <= fetch_addr; r_cnt <= int'(fetch_cnt); r_idx <= 0;
        ent_valid <= 1'b1; ent_data <= rd(fetch_addr);
      end else if (ent_valid && ent_ready) begin
        if (r_idx + 1 < r_cnt) begin
          r_idx <= r_idx + 1;
          ent_data <= rd(r_addr + 64'(8 * (r_idx + 1)));
        end else ent_valid <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_segs(input string req);
    int bad = -1;
    chk(seg_q.size() == exp_q.size(), req, "segment count", 64'(seg_q.size()), 64'(exp_q.size()));
    if (seg_q.size() == exp_q.size()) begin
      foreach (seg_q[i]) if (bad < 0 && seg_q[i] != exp_q[i]) bad = i;
      if (bad >= 0) chk(1'b0, req, "segment contents", {seg_q[bad].a[31:0], seg_q[bad].l},
                        {exp_q[bad].a[31:0], exp_q[bad].l});
      else chk(1'b1, req, "segment contents", 0, 0);
    end
  endtask

  task automatic run_walk(input logic [63:0] a1, input logic [63:0] a2, input logic [31:0] n,
                          input logic [3:0] m, output bit got_err, output logic [15:0] st);
    int t = 0;
    seg_q.delete(); fa_q.delete(); fc_q.delete(); exp_q.delete();
    got_err = 1'b0; st = '0;
    @(negedge clk); p1 = a1; p2 = a2; len = n; mps = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (t < 20000) begin
      if (done) break;
      if (err) begin got_err = 1'b1; st = err_status; break; end
      @(negedge clk); t++;
    end
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !seg_valid && !fetch_valid && !done && !err && err_status == 0,
        "R10", "reset outputs", {busy, seg_valid, fetch_valid, done, err}, 0);
  endtask

  task automatic t_single;
    bit e; logic [15:0] s;
    run_walk(64'h1000_0100, 64'h0, 32'h200, 4'd0, e, s);
    exp_q.push_back('{a: 64'h1000_0100, l: 32'h200});
    chk(!e, "R3", "single page no error", e, 0);
    chk(fa_q.size() == 0, "R3", "no fetch", fa_q.size(), 0);
    cmp_segs("R1");
  endtask

  task automatic t_cross;
    bit e; logic [15:0] s;
    run_walk(64'h2000_0F00, 64'h3000_0000, 32'h300, 4'd0, e, s);
    exp_q.push_back('{a: 64'h2000_0F00, l: 32'h100});
    exp_q.push_back('{a: 64'h3000_0000, l: 32'h200});
    chk(!e && fa_q.size() == 0, "R3", "direct second pointer", e, 0);
    cmp_segs("R3");
    run_walk(64'h2000_0F00, 64'h3000_0000, 32'h300, 4'd1, e, s);
    exp_q.push_back('{a: 64'h2000_0F00, l: 32'h300});
    cmp_segs("R1");
  endtask

  task automatic t_p1_zero;
    bit e; logic [15:0] s;
    run_walk(64'h0, 64'h3000_0000, 32'h100, 4'd0, e, s);
    chk(e, "R2", "zero ptr1 error", e, 1);
    chk(s == 16'h8002, "R10", "error status", s, 16'h8002);
    cmp_segs("R2");
  endtask

  task automatic t_p2_bad;
    bit e; logic [15:0] s;
    run_walk(64'h2000_0F00, 64'h3000_0010, 32'h300, 4'd0, e, s);
    chk(e, "R4", "misaligned direct ptr2", e, 1);
    cmp_segs("R4");
    run_walk(64'h2000_0F00, 64'h0, 32'h300, 4'd0, e, s);
    chk(e && s == 16'h8002, "R4", "zero ptr2", {e, s}, {1'b1, 16'h8002});
    cmp_segs("R4");
  endtask

  task automatic t_list;
    bit e; logic [15:0] s;
    for (int i = 0; i < 4; i++) mem[64'h5000_0000 + 64'(8 * i)] = 64'h6000_0000 + 64'(i) * 64'h100_0000;
    run_walk(64'h4000_0800, 64'h5000_0000, 32'h3A34, 4'd0, e, s);
    exp_q.push_back('{a: 64'h4000_0800, l: 32'h800});
    for (int i = 0; i < 4; i++)
      exp_q.push_back('{a: 64'h6000_0000 + 64'(i) * 64'h100_0000, l: (i == 3) ? 32'h234 : 32'h1000});
    chk(!e && fa_q.size() == 1, "R5", "one fetch", fa_q.size(), 1);
    if (fa_q.size() == 1) chk(fa_q[0] == 64'h5000_0000 && fc_q[0] == 4, "R5", "fetch addr/count",
                              {fa_q[0][31:0], 32'(fc_q[0])}, {32'h5000_0000, 32'd4});
    cmp_segs("R5");
  endtask

  task automatic t_chain(input bit bad_link);
    bit e; logic [15:0] s;
    logic [63:0] base = bad_link ? 64'h5400_0000 : 64'h5100_0000;
    for (int i = 0; i < 511; i++) mem[base + 64'(8 * i)] = 64'h7000_0000 + 64'(i) * 64'h1000;
    mem[base + 64'(8 * 511)] = bad_link ? 64'h5800_0008 : 64'h5800_0000;
    mem[64'h5800_0000] = 64'h9000_0000;
    mem[64'h5800_0008] = 64'h9000_1000;
    run_walk(64'h4000_0000, base, 32'h1000 + 32'd513 * 32'h1000, 4'd0, e, s);
    exp_q.push_back('{a: 64'h4000_0000, l: 32'h1000});
    for (int i = 0; i < 511; i++) exp_q.push_back('{a: 64'h7000_0000 + 64'(i) * 64'h1000, l: 32'h1000});
    if (bad_link) begin
      chk(e, "R8", "bad link error", e, 1);
      chk(fa_q.size() == 1, "R8", "no fetch after bad link", fa_q.size(), 1);
      cmp_segs("R8");
    end else begin
      exp_q.push_back('{a: 64'h9000_0000, l: 32'h1000});
      exp_q.push_back('{a: 64'h9000_1000, l: 32'h1000});
      chk(!e && fa_q.size() == 2, "R6", "two fetches", fa_q.size(), 2);
      if (fa_q.size() == 2) begin
        chk(fa_q[0] == base && fc_q[0] == 512, "R5", "first batch", {fa_q[0][31:0], 32'(fc_q[0])},
            {base[31:0], 32'd512});
        chk(fa_q[1] == 64'h5800_0000 && fc_q[1] == 2, "R6", "linked batch",
            {fa_q[1][31:0], 32'(fc_q[1])}, {32'h5800_0000, 32'd2});
      end
      cmp_segs("R6");
    end
  endtask

  task automatic t_bad_entry;
    bit e; logic [15:0] s;
    mem[64'h5200_0000] = 64'h6000_0000;
    mem[64'h5200_0008] = 64'h6100_0000;
    mem[64'h5200_0010] = 64'h6200_0010;
    mem[64'h5200_0018] = 64'h6300_0000;
    run_walk(64'h4000_0800, 64'h5200_0000, 32'h3A34, 4'd0, e, s);
    exp_q.push_back('{a: 64'h4000_0800, l: 32'h800});
    exp_q.push_back('{a: 64'h6000_0000, l: 32'h1000});
    exp_q.push_back('{a: 64'h6100_0000, l: 32'h1000});
    chk(e && s == 16'h8002, "R7", "bad entry error", {e, s}, {1'b1, 16'h8002});
    cmp_segs("R7");
    chk(!ent_valid && !busy, "R7", "batch drained, idle", {ent_valid, busy}, 0);
    run_walk(64'h1000_0100, 64'h0, 32'h200, 4'd0, e, s);
    exp_q.push_back('{a: 64'h1000_0100, l: 32'h200});
    cmp_segs("R7");
  endtask

  task automatic t_stall;
    int t = 0;
    seg_q.delete(); exp_q.delete();
    hold = 1'b1;
    @(negedge clk); p1 = 64'h1000_0040; p2 = 0; len = 32'h40; mps = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(seg_valid && seg_addr == 64'h1000_0040 && seg_len == 32'h40, "R9", "segment held",
        seg_addr, 64'h1000_0040);
    chk(!done && busy, "R10", "no done before accept", {done, busy}, 2'b01);
    p1 = 64'h2222_0000; len = 32'h80; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    chk(seg_addr == 64'h1000_0040 && seg_len == 32'h40, "R11", "start ignored while busy",
        seg_addr, 64'h1000_0040);
    hold = 1'b0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk(done, "R10", "done pulse", done, 1);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
    repeat (10) @(negedge clk);
    exp_q.push_back('{a: 64'h1000_0040, l: 32'h40});
    cmp_segs("R11");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_single();
    t_cross();
    t_p1_zero();
    t_p2_bad();
    t_list();
    t_chain(1'b0);
    t_chain(1'b1);
    t_bad_entry();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule